// File: doc/BRIEF.md
# Inhibit-Latched Angle Output Port

This block connects a free-running tracking angle counter to a host bus. Each time the counter reports a new value, the block raises a busy flag for a fixed number of clock cycles. A fixed number of cycles after busy rises, the new angle is copied into an output holding register. The host can set a freeze input to hold that register for as long as it likes. The tracking side is never stopped by the freeze: updates keep arriving, busy keeps pulsing, and the staged value keeps moving.

The held angle is read as two bytes. Each byte has its own read enable. When a byte's enable is low, that byte presents zeros and its output-enable flag is low, which stands in for a high-impedance driver. If an update arrives while busy is still high, it is parked in a one-deep holding slot. A newer arrival overwrites the parked value. The parked value starts its own pulse once the current pulse has ended. All timing is given in nanoseconds and converted to clock cycles from the clock frequency parameter.

Top module: `angle_out_port`

## Requirements
- R1: After reset, busy is 0, the held angle is 0 and no update is parked.
- R2: An update sampled while busy is low and nothing is parked raises busy on the next clock edge. Busy then stays high for exactly BUSY_CYC cycles (500 ns at 100 MHz, which is 50 cycles).
- R3: The held angle takes the new value on the DLY_CYC-th edge after busy rose (50 ns, which is 5 cycles), and not before. DLY_CYC is smaller than VALID_CYC (200 ns, which is 20 cycles), so the data has settled before the valid point.
- R4: The held angle never changes while busy is low.
- R5: If the freeze input is high at the load edge, the held angle keeps its old value. Busy still pulses for the full width.
- R6: Clearing the freeze input does not change the held angle by itself. The held angle moves only at the load point of the next pulse, and it then shows the angle of that pulse.
- R7: An update sampled while busy is high is parked, and the latest one wins. Busy goes low for exactly one cycle and then pulses again with the parked angle.
- R8: msb_oe equals en_msb. msb_data is held angle bits [15:8] when en_msb is 1, and 0 otherwise.
- R9: lsb_oe equals en_lsb. lsb_data is held angle bits [7:0] when en_lsb is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trk_update | input | 1 | One-cycle strobe: the tracking counter has a new value |
| trk_angle | input | 16 | Tracking counter value, sampled with trk_update |
| freeze | input | 1 | High: hold the output angle |
| en_msb | input | 1 | Read enable, upper byte |
| en_lsb | input | 1 | Read enable, lower byte |
| busy | output | 1 | Update pulse |
| msb_data | output | 8 | Upper byte of held angle, 0 when disabled |
| msb_oe | output | 1 | Upper byte driver enable |
| lsb_data | output | 8 | Lower byte of held angle, 0 when disabled |
| lsb_oe | output | 1 | Lower byte driver enable |

## Verification
The bench aims at a few timing corner cases:
- Updates that land mid-pulse and stack up. A design that dropped them, or kept the oldest one, would show a stale angle after the second pulse.
- A busy that is one cycle too short or too long, and a load edge one cycle early or late. Either would shift the byte outputs by one sample against the expected cycle.
- Freeze asserted across the load edge, and then released between pulses. A design that reloaded on release, or loaded while frozen, would change the bytes at a moment when they must hold.

// File: rtl/angle_out_pkg.sv
// Package: shared helpers for the angle output port.
// Assumes timing parameters are given in whole nanoseconds and the clock in MHz.
package angle_out_pkg;

    // Round a duration in ns up to whole clock cycles at the given clock rate.
    function automatic int ns_to_cyc(input int ns, input int clk_mhz);
        return (ns * clk_mhz + 999) / 1000;
    endfunction

    // Sequencer phase.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PULSE = 1'b1
    } phase_t;

endpackage

// File: rtl/upd_park.sv
// Module: one-deep parking slot for updates that arrive while a pulse runs.
// Assumes 'consume' is only raised when the sequencer starts a pulse from idle.
module upd_park #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] ang,
    input  logic         pulsing,
    input  logic         consume,
    output logic         held_v,
    output logic [W-1:0] held_ang
);
    // Park the latest in-pulse update; clear when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v   <= 1'b0;
            held_ang <= '0;
        end else if (pulsing && upd) begin
            held_v   <= 1'b1;
            held_ang <= ang;
        end else if (consume) begin
            held_v   <= 1'b0;
        end
    end
endmodule

// File: rtl/busy_seq.sv
// Module: busy pulse sequencer. Starts a pulse from idle on a fresh or parked
// update, raises a one-cycle load strobe DLY_CYC edges after busy rises and
// ends the pulse after BUSY_CYC cycles. Assumes 0 < DLY_CYC < BUSY_CYC.
module busy_seq
    import angle_out_pkg::*;
#(
    parameter int W        = 16,
    parameter int BUSY_CYC = 50,
    parameter int DLY_CYC  = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] ang,
    input  logic         held_v,
    input  logic [W-1:0] held_ang,
    output logic         busy,
    output logic         start,
    output logic         load,
    output logic [W-1:0] staged
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(BUSY_CYC - 1);
    localparam logic [CW-1:0] LOAD_CNT = CW'(DLY_CYC - 1);

    phase_t        ph_q;
    logic [CW-1:0] cnt_q;

    // Start condition: idle and either a new or a parked update is present.
    assign start = (ph_q == PH_IDLE) && (upd || held_v);
    // Load strobe: the edge DLY_CYC cycles after busy went high.
    assign load  = (ph_q == PH_PULSE) && (cnt_q == LOAD_CNT);
    assign busy  = (ph_q == PH_PULSE);

    // Phase, cycle count and staged angle for the running pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            staged <= '0;
        end else if (start) begin
            ph_q   <= PH_PULSE;
            cnt_q  <= '0;
            staged <= upd ? ang : held_ang;
        end else if (ph_q == PH_PULSE) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_CNT) begin
                ph_q <= PH_IDLE;
            end
        end
    end
endmodule

// File: rtl/angle_hold.sv
// Module: output holding register. Copies the staged angle on the load strobe
// unless frozen; never changes at any other time.
module angle_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         freeze,
    input  logic [W-1:0] staged,
    output logic [W-1:0] held
);
    // Take the staged angle only at an unfrozen load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (load && !freeze) begin
            held <= staged;
        end
    end
endmodule

// File: rtl/byte_drv.sv
// Module: one byte lane of the read port. The output-enable flag stands in for
// a three-state driver; a disabled lane shows zeros.
module byte_drv #(
    parameter int W   = 16,
    parameter int IDX = 0
) (
    input  logic [W-1:0] word,
    input  logic         en,
    output logic [7:0]   data,
    output logic         oe
);
    // Select this lane's byte and gate it with the enable.
    always_comb begin
        oe   = en;
        data = en ? word[IDX*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/angle_out_port.sv
// Module: top of the inhibit-latched angle output port. Feeds tracker updates
// through a busy pulse sequencer into a freezable holding register, read as
// two enabled byte lanes. Assumes ANGLE_W is 16 (two lanes) and trk_update is
// a one-cycle strobe.
module angle_out_port
    import angle_out_pkg::*;
#(
    parameter int ANGLE_W  = 16,
    parameter int CLK_MHZ  = 100,
    parameter int BUSY_NS  = 500,
    parameter int DLY_NS   = 50,
    parameter int VALID_NS = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trk_update,
    input  logic [ANGLE_W-1:0] trk_angle,
    input  logic               freeze,
    input  logic               en_msb,
    input  logic               en_lsb,
    output logic               busy,
    output logic [7:0]         msb_data,
    output logic               msb_oe,
    output logic [7:0]         lsb_data,
    output logic               lsb_oe
);
    localparam int BUSY_CYC  = ns_to_cyc(BUSY_NS, CLK_MHZ);
    localparam int DLY_CYC   = ns_to_cyc(DLY_NS, CLK_MHZ);
    localparam int VALID_CYC = ns_to_cyc(VALID_NS, CLK_MHZ);
    localparam int LANES     = ANGLE_W / 8;

    logic               held_v;
    logic [ANGLE_W-1:0] held_ang;
    logic               start;
    logic               load;
    logic [ANGLE_W-1:0] staged;
    logic [ANGLE_W-1:0] held;
    logic [LANES-1:0]   lane_en;
    logic [7:0]         lane_data [LANES];
    logic [LANES-1:0]   lane_oe;

    upd_park #(.W(ANGLE_W)) u_park (
        .clk(clk), .rst_n(rst_n), .upd(trk_update), .ang(trk_angle),
        .pulsing(busy), .consume(start), .held_v(held_v), .held_ang(held_ang)
    );

    busy_seq #(.W(ANGLE_W), .BUSY_CYC(BUSY_CYC), .DLY_CYC(DLY_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .upd(trk_update), .ang(trk_angle),
        .held_v(held_v), .held_ang(held_ang), .busy(busy), .start(start),
        .load(load), .staged(staged)
    );

    angle_hold #(.W(ANGLE_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load), .freeze(freeze),
        .staged(staged), .held(held)
    );

    // Lane enables: lane 0 is the low byte, the top lane the high byte.
    assign lane_en = {en_msb, en_lsb};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        byte_drv #(.W(ANGLE_W), .IDX(g)) u_lane (
            .word(held), .en(lane_en[g]), .data(lane_data[g]), .oe(lane_oe[g])
        );
    end

    // Map the lanes onto the named byte ports.
    assign msb_data = lane_data[LANES-1];
    assign msb_oe   = lane_oe[LANES-1];
    assign lsb_data = lane_data[0];
    assign lsb_oe   = lane_oe[0];
endmodule

// File: rtl/angle_out_chk.sv
// Module: protocol checker for angle_out_port, bound to every instance.
// Counts busy-high cycles locally so no window depends on a deep $past.
module angle_out_chk #(
    parameter int W         = 16,
    parameter int BUSY_CYC  = 50,
    parameter int DLY_CYC   = 5,
    parameter int VALID_CYC = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         freeze,
    input logic         held_v,
    input logic [W-1:0] held,
    input logic         en_msb,
    input logic         en_lsb,
    input logic [7:0]   msb_data,
    input logic         msb_oe,
    input logic [7:0]   lsb_data,
    input logic         lsb_oe
);
    localparam int CW = $clog2(BUSY_CYC + 2);
    logic [CW-1:0] hi_cnt;

    // Count cycles busy has been high since it rose.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_cnt <= '0;
        else if (busy) hi_cnt <= hi_cnt + 1'b1;
        else hi_cnt <= '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && held == '0 && !held_v));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (hi_cnt == CW'(BUSY_CYC)));

    // R2
    pulse_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (hi_cnt < CW'(BUSY_CYC)));

    // R3
    load_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> (busy && hi_cnt == CW'(DLY_CYC) && DLY_CYC < VALID_CYC));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> $stable(held));

    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(held) |-> !$past(freeze));

    // R7
    parked_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && held_v) |=> busy);

    // R8
    msb_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msb_oe == en_msb) && (msb_data == (en_msb ? held[W-1 -: 8] : 8'h00)));

    // R9
    lsb_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsb_oe == en_lsb) && (lsb_data == (en_lsb ? held[7:0] : 8'h00)));
endmodule

bind angle_out_port angle_out_chk #(
    .W(ANGLE_W), .BUSY_CYC(BUSY_CYC), .DLY_CYC(DLY_CYC), .VALID_CYC(VALID_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .freeze(freeze), .held_v(held_v),
    .held(held), .en_msb(en_msb), .en_lsb(en_lsb), .msb_data(msb_data),
    .msb_oe(msb_oe), .lsb_data(lsb_data), .lsb_oe(lsb_oe)
);

// File: tb/sim_angle_out_port.sv
module sim_angle_out_port;
    localparam int BUSY = 50;
    localparam int DLY  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trk_update = 1'b0;
    logic [15:0] trk_angle = '0;
    logic        freeze = 1'b0;
    logic        en_msb = 1'b1;
    logic        en_lsb = 1'b1;
    logic        busy;
    logic [7:0]  msb_data, lsb_data;
    logic        msb_oe, lsb_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    angle_out_port u0 (
        .clk(clk), .rst_n(rst_n), .trk_update(trk_update), .trk_angle(trk_angle),
        .freeze(freeze), .en_msb(en_msb), .en_lsb(en_lsb), .busy(busy),
        .msb_data(msb_data), .msb_oe(msb_oe), .lsb_data(lsb_data), .lsb_oe(lsb_oe)
    );

    always #5 clk = ~clk;

    // Reference model built from the requirements.
    logic        m_busy = 1'b0;
    int          m_cnt  = 0;
    logic [15:0] m_stage = '0, m_out = '0, m_park = '0;
    logic        m_park_v = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_cnt <= 0; m_stage <= '0; m_out <= '0;
            m_park <= '0; m_park_v <= 1'b0;
        end else if (m_busy) begin
            m_cnt <= m_cnt + 1;
            if (trk_update) begin m_park_v <= 1'b1; m_park <= trk_angle; end
            if (m_cnt == DLY - 1 && !freeze) m_out <= m_stage;
            if (m_cnt == BUSY - 1) m_busy <= 1'b0;
        end else if (trk_update || m_park_v) begin
            m_busy <= 1'b1; m_cnt <= 0; m_park_v <= 1'b0;
            m_stage <= trk_update ? trk_angle : m_park;
        end
    end

    function automatic logic [7:0] lane(input logic [15:0] w, input bit hi, input logic en);
        return en ? (hi ? w[15:8] : w[7:0]) : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] port_word();
        return {msb_data, lsb_data};
    endfunction

    // Continuous comparison with the model at every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 busy", 32'(busy), 32'(m_busy));
            chk("R8 msb", {23'd0, msb_oe, msb_data}, {23'd0, en_msb, lane(m_out, 1'b1, en_msb)});
            chk("R9 lsb", {23'd0, lsb_oe, lsb_data}, {23'd0, en_lsb, lane(m_out, 1'b0, en_lsb)});
        end
    end

    task automatic send(input logic [15:0] a);
        @(negedge clk); trk_update = 1'b1; trk_angle = a;
        @(negedge clk); trk_update = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports while still in reset
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 word", 32'(port_word()), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 32'(busy), 32'd0);

        // R2, R3: single update, walk the pulse cycle by cycle
        send(16'hA5C3);
        for (int k = 0; k <= BUSY; k++) begin
            chk("R2 width", 32'(busy), 32'(k < BUSY));
            chk("R3 load", 32'(port_word()), (k < DLY) ? 32'h0 : 32'hA5C3);
            if (k < BUSY) @(negedge clk);
        end

        // R5: frozen across load point; pulse still runs, value held
        freeze = 1'b1;
        send(16'h1234);
        chk("R5 pulse", 32'(busy), 32'd1);
        repeat (DLY + 2) @(negedge clk);
        chk("R5 held", 32'(port_word()), 32'hA5C3);
        wait_idle();
        // R6: release does not reload by itself
        freeze = 1'b0;
        repeat (8) @(negedge clk);
        chk("R6 release", 32'(port_word()), 32'hA5C3);
        send(16'h0F0F);
        repeat (DLY) @(negedge clk);
        chk("R6 next", 32'(port_word()), 32'h0F0F);
        wait_idle();

        // R7: stacked updates mid-pulse; latest wins, one idle cycle
        send(16'h1111);
        repeat (8) @(negedge clk);
        send(16'h2222);
        repeat (8) @(negedge clk);
        send(16'h3333);
        wait_idle();
        chk("R7 gap", 32'(busy), 32'd0);
        @(negedge clk);
        chk("R7 restart", 32'(busy), 32'd1);
        repeat (DLY) @(negedge clk);
        chk("R7 latest", 32'(port_word()), 32'h3333);
        // R4: stays put after the pulse ends
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R4 idle", 32'(port_word()), 32'h3333);

        // R8, R9: lane enables
        en_msb = 1'b0; @(negedge clk);
        chk("R8 off", {23'd0, msb_oe, msb_data}, 32'h0);
        chk("R9 on", {23'd0, lsb_oe, lsb_data}, 32'h133);
        en_msb = 1'b1; en_lsb = 1'b0; @(negedge clk);
        chk("R9 off", {23'd0, lsb_oe, lsb_data}, 32'h0);
        chk("R8 on", {23'd0, msb_oe, msb_data}, 32'h133);
        en_lsb = 1'b1;

        // Random phase, compared against the model every cycle
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            trk_update = ($urandom_range(0, 29) == 0);
            trk_angle  = 16'($urandom);
            if ($urandom_range(0, 99) == 0) freeze = ~freeze;
            en_msb = ($urandom_range(0, 7) != 0);
            en_lsb = ($urandom_range(0, 7) != 0);
        end
        @(negedge clk); trk_update = 1'b0;
        repeat (2 * BUSY + 4) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule